// File: doc/BRIEF.md
# UART Event Identification Register

This block gathers every interrupt event source of a serial port that works either as a UART or as an infrared link. It presents them as one 8-bit readable event word and drives a single interrupt line. The surrounding port logic supplies level indications: transmitter idle, transmit holding register or transmit FIFO below its threshold, and receive data or receive FIFO at its threshold or timed out. It also supplies line-error and overrun/underrun indications, the four modem-status change bits and a pulse at each DMA terminal count. Software reads the word through a one-cycle read strobe.

The meaning of several bits depends on context. A FIFO-enable flag switches between the holding-register view and the FIFO-threshold view. A two-bit mode input selects which error source is reported. In infrared modes, a select bit can suppress the modem-status event. The DMA event is sticky and is cleared by reading the word. The line, modem and data-level events follow their sources through one register stage. The interrupt output is the OR of the six live event bits, each gated by its own enable bit.

Top module: `uart_evt_id`

## Requirements
- R1: Bits 7 and 6 of `rd_data` always read as 0.
- R2: While `rst_n` is low, `rd_data` reads 8'h22 (bits 5 and 1 set, all others clear).
- R3: Bit 5 shows the value `tx_empty` had at the previous rising clock edge.
- R4: A `dma_tc` pulse sets bit 4 at the next edge. Bit 4 then stays set until a cycle with `rd_en` high, and clears at the edge that ends that cycle.
- R5: When `dma_tc` and `rd_en` are high in the same cycle, bit 4 is set after that edge, whatever its prior value.
- R6: With `mode` = 0 (UART), bit 3 is the OR of the four `msr_chg` bits registered at the previous edge.
- R7: With `mode` = 1, 2 or 3 (infrared), bit 3 behaves as in R6 when `ir_ms_sel` is 0 and is 0 when `ir_ms_sel` is 1.
- R8: Bit 2 is the registered `ovr_udr` when `mode` = 2 (consumer IR), and the registered `rx_err_brk` for every other mode.
- R9: Bit 1 is the registered `thr_empty` when `fifo_en` is 0, and the registered `tx_below_thr` when `fifo_en` is 1.
- R10: Bit 0 is the registered `rx_char_avail` when `fifo_en` is 0, and the registered OR of `rx_at_thr` and `rx_timeout` when `fifo_en` is 1.
- R11: `irq` is high in exactly the cycles where some bit i (0 to 5) of `rd_data` and bit i of `irq_en` are both 1; it depends combinationally on `irq_en`.
- R12: A read leaves bits 5 to 0 other than bit 4 exactly as the sources dictate, so a read changes no other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 UART, 1 standard IR, 2 consumer IR, 3 treated as standard IR |
| fifo_en | input | 1 | FIFOs enabled |
| ir_ms_sel | input | 1 | In IR modes, 1 forces the modem event to 0 |
| tx_empty | input | 1 | Transmitter fully idle |
| dma_tc | input | 1 | DMA terminal count pulse |
| msr_chg | input | 4 | Modem-status change bits |
| rx_err_brk | input | 1 | Receiver error or break reported |
| ovr_udr | input | 1 | Receiver overrun or transmitter underrun |
| thr_empty | input | 1 | Transmit holding register empty |
| tx_below_thr | input | 1 | Transmit FIFO level below threshold |
| rx_char_avail | input | 1 | Character present in receive holding register |
| rx_at_thr | input | 1 | Receive FIFO level at or above threshold |
| rx_timeout | input | 1 | Receive FIFO timeout |
| irq_en | input | 6 | Per-bit interrupt enables for bits 5:0 |
| rd_en | input | 1 | One-cycle read strobe |
| rd_data | output | 8 | Event word |
| irq | output | 1 | Interrupt request |

## Verification
Every event bit except the DMA flag appears on `rd_data` after one register, so the bench drives a source vector just after a falling edge and checks at the next falling edge. Exactly one rising edge lies between those two points. The DMA flag is checked in the cycle the read strobe is high, where it still shows the value being read, and again one falling edge later, where the clear or the coincident set has taken effect. `irq` has no register of its own; it is checked at the same falling edge as `rd_data`, against the enable mask applied in that cycle.

// File: rtl/uart_evt_id_pkg.sv
// Package: shared definitions for the UART event identification register.
// Bit positions are fixed by software decoding of the event word.
package uart_evt_id_pkg;

    typedef enum logic [1:0] {
        MODE_UART = 2'd0,
        MODE_SIR  = 2'd1,
        MODE_CIR  = 2'd2,
        MODE_RSV  = 2'd3
    } op_mode_e;

    localparam int EVT_RXLVL = 0;
    localparam int EVT_TXLVL = 1;
    localparam int EVT_LINE  = 2;
    localparam int EVT_MODEM = 3;
    localparam int EVT_DMA   = 4;
    localparam int EVT_TXIDL = 5;

    localparam int N_LIVE    = 6;   // event bits that can raise the interrupt
    localparam int N_LVL     = 4;   // level-following bits 3:0

    localparam logic [N_LIVE-1:0] LIVE_RST = 6'b10_0010;

endpackage

// File: rtl/uart_evt_id_src_sel.sv
// Module: uart_evt_id_src_sel
// Picks, per event bit 3:0, the source that matters for the current FIFO
// setting and operating mode. Purely combinational; the caller registers it.
// Assumes mode 3 is unused and handles it like standard IR.
module uart_evt_id_src_sel
    import uart_evt_id_pkg::*;
#(
    parameter int MSR_W = 4
) (
    input  logic [1:0]       mode,
    input  logic             fifo_en,
    input  logic             ir_ms_sel,
    input  logic [MSR_W-1:0] msr_chg,
    input  logic             rx_err_brk,
    input  logic             ovr_udr,
    input  logic             thr_empty,
    input  logic             tx_below_thr,
    input  logic             rx_char_avail,
    input  logic             rx_at_thr,
    input  logic             rx_timeout,
    output logic [N_LVL-1:0] lvl_next
);

    op_mode_e mode_e;
    logic     modem_any;

    assign mode_e    = op_mode_e'(mode);
    assign modem_any = |msr_chg;

    // Decode each level event from its mode-dependent source.
    always_comb begin
        lvl_next = '0;
        unique case (mode_e)
            MODE_UART: lvl_next[EVT_MODEM] = modem_any;
            MODE_SIR,
            MODE_CIR,
            MODE_RSV:  lvl_next[EVT_MODEM] = modem_any & ~ir_ms_sel;
        endcase
        lvl_next[EVT_LINE]  = (mode_e == MODE_CIR) ? ovr_udr : rx_err_brk;
        lvl_next[EVT_TXLVL] = fifo_en ? tx_below_thr : thr_empty;
        lvl_next[EVT_RXLVL] = fifo_en ? (rx_at_thr | rx_timeout) : rx_char_avail;
    end

endmodule

// File: rtl/uart_evt_id_dma_flag.sv
// Module: uart_evt_id_dma_flag
// Sticky terminal-count flag. Set by a pulse, cleared by a one-cycle read.
// A set in the same cycle as a read wins, so no count can be lost.
module uart_evt_id_dma_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_clr_i,
    output logic flag_o
);

    // Hold, set or clear the flag with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (rd_clr_i)
            flag_o <= 1'b0;
    end

endmodule

// File: rtl/uart_evt_id_irq_gen.sv
// Module: uart_evt_id_irq_gen
// Masks each live event bit with its enable and ORs the results.
// Combinational, so the interrupt tracks the event word in the same cycle.
module uart_evt_id_irq_gen #(
    parameter int N = 6
) (
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);

    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = evt_i[i] & en_i[i];
    end

    assign irq_o = |gated;

endmodule

// File: rtl/uart_evt_id.sv
// Module: uart_evt_id (top)
// Event identification register for a UART/IR port. Bits 3:0 and 5 follow
// their sources through one register; bit 4 is the sticky DMA flag; bits
// 7:6 are reserved and read 0. Assumes rd_en is a single-cycle strobe per
// read and that all inputs are synchronous to clk.
module uart_evt_id
    import uart_evt_id_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int MSR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             fifo_en,
    input  logic             ir_ms_sel,
    input  logic             tx_empty,
    input  logic             dma_tc,
    input  logic [MSR_W-1:0] msr_chg,
    input  logic             rx_err_brk,
    input  logic             ovr_udr,
    input  logic             thr_empty,
    input  logic             tx_below_thr,
    input  logic             rx_char_avail,
    input  logic             rx_at_thr,
    input  logic             rx_timeout,
    input  logic [5:0]       irq_en,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);

    localparam int N_RSV = REG_W - N_LIVE;

    logic [N_LVL-1:0]  lvl_next;
    logic [N_LVL-1:0]  lvl_q;
    logic              txidl_q;
    logic              dma_q;
    logic [N_LIVE-1:0] live;

    uart_evt_id_src_sel #(.MSR_W(MSR_W)) u_src_sel (
        .mode          (mode),
        .fifo_en       (fifo_en),
        .ir_ms_sel     (ir_ms_sel),
        .msr_chg       (msr_chg),
        .rx_err_brk    (rx_err_brk),
        .ovr_udr       (ovr_udr),
        .thr_empty     (thr_empty),
        .tx_below_thr  (tx_below_thr),
        .rx_char_avail (rx_char_avail),
        .rx_at_thr     (rx_at_thr),
        .rx_timeout    (rx_timeout),
        .lvl_next      (lvl_next)
    );

    // Register level events; reset values come from the package constant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= LIVE_RST[N_LVL-1:0];
            txidl_q <= LIVE_RST[EVT_TXIDL];
        end else begin
            lvl_q   <= lvl_next;
            txidl_q <= tx_empty;
        end
    end

    uart_evt_id_dma_flag u_dma_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (dma_tc),
        .rd_clr_i (rd_en),
        .flag_o   (dma_q)
    );

    // Assemble the live event bits.
    always_comb begin
        live              = '0;
        live[N_LVL-1:0]   = lvl_q;
        live[EVT_DMA]     = dma_q;
        live[EVT_TXIDL]   = txidl_q;
    end

    assign rd_data[N_LIVE-1:0] = live;

    for (genvar r = 0; r < N_RSV; r++) begin : g_rsv
        assign rd_data[N_LIVE+r] = 1'b0;
    end

    uart_evt_id_irq_gen #(.N(N_LIVE)) u_irq_gen (
        .evt_i (live),
        .en_i  (irq_en),
        .irq_o (irq)
    );

endmodule

// File: rtl/uart_evt_id_chk.sv
// Module: uart_evt_id_chk
// Property checker for uart_evt_id, attached by bind below.
module uart_evt_id_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       ir_ms_sel,
    input logic       tx_empty,
    input logic       dma_tc,
    input logic [5:0] irq_en,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       irq
);

    logic past_ok;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00);

    // R3
    txidl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> rd_data[5] == $past(tx_empty));

    // R4
    dma_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tc |=> rd_data[4]);

    // R4
    dma_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !dma_tc) |=> !rd_data[4]);

    // R4
    dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[4] && !rd_en) |=> rd_data[4]);

    // R7
    ir_modem_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && ir_ms_sel) |=> !rd_data[3]);

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 6'd0) |-> !irq);

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> ((rd_data[5:0] & irq_en) == 6'd0));

endmodule

bind uart_evt_id uart_evt_id_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .ir_ms_sel (ir_ms_sel),
    .tx_empty  (tx_empty),
    .dma_tc    (dma_tc),
    .irq_en    (irq_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .irq       (irq)
);

// File: tb/uart_evt_id_bench.sv
// Bench: exhaustive sweep of the level-event sources over every mode and
// FIFO setting, plus directed DMA flag, read and reset sequences.
module uart_evt_id_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = '0;
    logic       fifo_en = 0, ir_ms_sel = 0, tx_empty = 0, dma_tc = 0;
    logic [3:0] msr_chg = '0;
    logic       rx_err_brk = 0, ovr_udr = 0, thr_empty = 0, tx_below_thr = 0;
    logic       rx_char_avail = 0, rx_at_thr = 0, rx_timeout = 0;
    logic [5:0] irq_en = '0;
    logic       rd_en = 0;
    logic [7:0] rd_data;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_evt_id u_uart_evt_id (
        .clk(clk), .rst_n(rst_n), .mode(mode), .fifo_en(fifo_en),
        .ir_ms_sel(ir_ms_sel), .tx_empty(tx_empty), .dma_tc(dma_tc),
        .msr_chg(msr_chg), .rx_err_brk(rx_err_brk), .ovr_udr(ovr_udr),
        .thr_empty(thr_empty), .tx_below_thr(tx_below_thr),
        .rx_char_avail(rx_char_avail), .rx_at_thr(rx_at_thr),
        .rx_timeout(rx_timeout), .irq_en(irq_en), .rd_en(rd_en),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] exp;
        logic       exp_irq;

        // R2: reset values, irq masked and unmasked
        repeat (2) @(negedge clk);
        check(rd_data == 8'h22, "R2 reset word", rd_data, 8'h22);
        check(irq == 1'b0, "R11 irq masked in reset", {7'd0, irq}, 8'h0);
        irq_en = 6'h3f;
        #1;
        check(irq == 1'b1, "R11 irq from reset bits", {7'd0, irq}, 8'h1);
        irq_en = 6'h10;
        #1;
        check(irq == 1'b0, "R11 irq bit4 only", {7'd0, irq}, 8'h0);
        @(negedge clk);
        rst_n = 1'b1;
        irq_en = '0;
        @(negedge clk);
        check(rd_data == 8'h00, "R3 R9 after reset, sources low", rd_data, 8'h00);

        // R1 R3 R6 R7 R8 R9 R10 R11: exhaustive sweep of level sources
        for (int v = 0; v < 32768; v++) begin
            msr_chg       = v[3:0];
            rx_err_brk    = v[4];
            ovr_udr       = v[5];
            thr_empty     = v[6];
            tx_below_thr  = v[7];
            rx_char_avail = v[8];
            rx_at_thr     = v[9];
            rx_timeout    = v[10];
            fifo_en       = v[11];
            ir_ms_sel     = v[12];
            mode          = v[14:13];
            tx_empty      = v[3] ^ v[9] ^ v[13];
            irq_en        = v[5:0] ^ v[14:9];
            exp = 8'h00;
            exp[5] = v[3] ^ v[9] ^ v[13];
            exp[3] = (v[14:13] == 2'd0 || !v[12]) ? (|v[3:0]) : 1'b0;
            exp[2] = (v[14:13] == 2'd2) ? v[5] : v[4];
            exp[1] = v[11] ? v[7] : v[6];
            exp[0] = v[11] ? (v[9] | v[10]) : v[8];
            exp_irq = |(exp[5:0] & irq_en);
            @(negedge clk);
            check(rd_data[7:6] == 2'b00, "R1 reserved", rd_data, exp);
            check(rd_data[5] == exp[5], "R3 tx idle", rd_data, exp);
            if (v[14:13] == 2'd0)
                check(rd_data[3] == exp[3], "R6 modem uart", rd_data, exp);
            else
                check(rd_data[3] == exp[3], "R7 modem ir", rd_data, exp);
            check(rd_data[2] == exp[2], "R8 line event", rd_data, exp);
            check(rd_data[1] == exp[1], "R9 tx level", rd_data, exp);
            check(rd_data[0] == exp[0], "R10 rx level", rd_data, exp);
            check(rd_data[4] == 1'b0, "R4 dma idle", rd_data, exp);
            check(irq == exp_irq, "R11 irq", {7'd0, irq}, {7'd0, exp_irq});
        end

        // Fixed source pattern for the DMA tests: word bits 5,2,0 set.
        mode = 2'd0; fifo_en = 0; ir_ms_sel = 0; msr_chg = '0;
        tx_empty = 1; rx_err_brk = 1; ovr_udr = 0; thr_empty = 0;
        tx_below_thr = 0; rx_char_avail = 1; rx_at_thr = 0; rx_timeout = 0;
        irq_en = 6'h10;
        @(negedge clk);
        check(rd_data == 8'h25, "R12 base pattern", rd_data, 8'h25);
        check(irq == 1'b0, "R11 irq only bit4 enabled", {7'd0, irq}, 8'h0);

        // R4: pulse sets and holds
        dma_tc = 1;
        @(negedge clk);
        dma_tc = 0;
        check(rd_data == 8'h35, "R4 dma set", rd_data, 8'h35);
        check(irq == 1'b1, "R11 irq from dma", {7'd0, irq}, 8'h1);
        repeat (3) @(negedge clk);
        check(rd_data == 8'h35, "R4 dma held", rd_data, 8'h35);

        // R4 R12: read shows the flag, then clears only bit 4
        rd_en = 1;
        #1;
        check(rd_data == 8'h35, "R4 read returns flag", rd_data, 8'h35);
        @(negedge clk);
        rd_en = 0;
        check(rd_data == 8'h25, "R4 R12 read clears bit4 only", rd_data, 8'h25);
        check(irq == 1'b0, "R11 irq drops after read", {7'd0, irq}, 8'h0);

        // R5: coincident set and read while flag set
        dma_tc = 1;
        @(negedge clk);
        dma_tc = 0;
        check(rd_data[4] == 1'b1, "R4 set again", rd_data, 8'h35);
        dma_tc = 1; rd_en = 1;
        @(negedge clk);
        dma_tc = 0; rd_en = 0;
        check(rd_data == 8'h35, "R5 set wins over read (flag set)", rd_data, 8'h35);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        check(rd_data == 8'h25, "R4 clear", rd_data, 8'h25);

        // R5: coincident set and read while flag clear
        dma_tc = 1; rd_en = 1;
        @(negedge clk);
        dma_tc = 0; rd_en = 0;
        check(rd_data == 8'h35, "R5 set wins over read (flag clear)", rd_data, 8'h35);

        // R12: read with all level bits set changes nothing but bit 4
        thr_empty = 1; msr_chg = 4'h8;
        @(negedge clk);
        check(rd_data == 8'h3f, "R12 all live bits set", rd_data, 8'h3f);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        check(rd_data == 8'h2f, "R12 read leaves other bits", rd_data, 8'h2f);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        check(rd_data == 8'h2f, "R12 read with flag clear", rd_data, 8'h2f);

        // R2: reset mid-run restores the reset word
        rst_n = 0;
        @(negedge clk);
        check(rd_data == 8'h22, "R2 reset mid-run", rd_data, 8'h22);
        rst_n = 1;

        done = 1;
        summary();
        $finish;
    end

endmodule